// File: doc/BRIEF.md
# Wide Unsigned Multiplier Built from Byte Partial Products

This block forms the full 32-bit product of two unsigned 16-bit operands. The only multiply resource it uses is a small 8x8 unit that registers its result one clock after its inputs are sampled. Each operand is cut into two bytes, which gives four byte pairs. Every pair yields one partial product. That partial product is moved up by eight bits per byte of significance, and the four shifted terms are added into the final result.

A build-time parameter picks one of two structures. The parallel structure instantiates one byte multiplier per pair and adds the four registered terms, so a result appears one cycle after the request. The serial structure keeps a single byte multiplier and feeds it the pairs one per cycle. A shift-and-add accumulator collects the terms, and the result appears four cycles after the request. The serial structure uses a quarter of the multiply logic and accepts a new request only once the current one is finished.

A caller holds `start` high for one cycle with the operands valid. It then waits for `done`, and in that cycle `product` is valid. The last product stays on the output until the next one is ready.

Top module: `bytewise_mul`

## Requirements
- R1: When `done` is high, `product` equals the unsigned 32-bit value a*b, using the operands that were presented with the accepted `start`.
- R2: With the parallel structure (ARCH = MUL_PARALLEL), `done` is high in the cycle right after every cycle in which `start` is high. `start` may be high on consecutive cycles, and each request gets its own result.
- R3: With the serial structure (ARCH = MUL_SERIAL), a request that is accepted at a clock edge raises `done` after the fourth edge that follows it. That is a latency of four cycles.
- R4: In the serial structure, `done` stays high for exactly one cycle per accepted request.
- R5: In the serial structure, `start` is ignored from the accepting edge until the edge that raises `done`. Operands offered in that window change neither the result nor the number of `done` pulses.
- R6: `product` changes only in a cycle where `done` is high. Between results it holds the last product.
- R7: While `rst_n` is low (active low, synchronous), `done` and `product` are driven to zero.
- R8: Boundary operands are exact: 0xFFFF*0xFFFF gives 0xFFFE0001, a zero operand gives 0, and 0x0100*0x0100 gives 0x00010000.
- R9: In the serial structure, a `start` offered in the same cycle that `done` is high is accepted. Its result follows four cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication of `a` and `b` |
| a | input | 16 | Multiplicand, unsigned |
| b | input | 16 | Multiplier, unsigned |
| done | output | 1 | Result valid in this cycle |
| product | output | 32 | Unsigned product, held between results |

## Verification
The bench builds two copies side by side with 16-bit operands and 8-bit slices, one with ARCH = MUL_PARALLEL and one with ARCH = MUL_SERIAL. The parallel copy makes back-to-back requests and the one-cycle result timing reachable. The serial copy makes the four-cycle sequencing, the busy window in which requests are dropped, and the hand-off of a new request in the cycle that `done` is high reachable. Both copies are driven with the all-ones, zero and single-bit boundary operands, so that every partial-product shift position carries a carry or an isolated bit.

// File: rtl/mulw_pkg.sv
package mulw_pkg;

   typedef enum logic {
      MUL_PARALLEL = 1'b0,
      MUL_SERIAL   = 1'b1
   } mul_arch_e;

   // Left shift applied to byte pair k: low slice index k%n of a,
   // high slice index k/n of b.
   function automatic int part_shift(input int k, input int nslice, input int sw);
      return sw * ((k % nslice) + (k / nslice));
   endfunction

endpackage

// File: rtl/mulw_slice.sv
module mulw_slice #(
   parameter int SW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [SW-1:0]   x,
   input  logic [SW-1:0]   y,
   output logic [2*SW-1:0] p
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         p <= '0;
      else if (en)
         p <= {{SW{1'b0}}, x} * {{SW{1'b0}}, y};
   end

endmodule

// File: rtl/mulw_par.sv
module mulw_par #(
   parameter int OPW = 16,
   parameter int SW  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OPW-1:0]   a,
   input  logic [OPW-1:0]   b,
   output logic             done,
   output logic [2*OPW-1:0] product
);
   import mulw_pkg::*;

   localparam int NSLICE = OPW / SW;
   localparam int NPART  = NSLICE * NSLICE;
   localparam int PW     = 2 * OPW;

   logic [2*SW-1:0] part [NPART];

   for (genvar j = 0; j < NSLICE; j++) begin : g_bsl
      for (genvar i = 0; i < NSLICE; i++) begin : g_asl
         mulw_slice #(.SW(SW)) u_slice (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (start),
            .x    (a[i*SW +: SW]),
            .y    (b[j*SW +: SW]),
            .p    (part[j*NSLICE + i])
         );
      end
   end

   always_comb begin
      product = '0;
      for (int k = 0; k < NPART; k++)
         product = product +
                   ({{(PW-2*SW){1'b0}}, part[k]} << part_shift(k, NSLICE, SW));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) done <= 1'b0;
      else        done <= start;
   end

endmodule

// File: rtl/mulw_ser.sv
module mulw_ser #(
   parameter int OPW = 16,
   parameter int SW  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OPW-1:0]   a,
   input  logic [OPW-1:0]   b,
   output logic             done,
   output logic [2*OPW-1:0] product
);
   import mulw_pkg::*;

   localparam int NSLICE = OPW / SW;
   localparam int NPART  = NSLICE * NSLICE;
   localparam int PW     = 2 * OPW;
   localparam int CW     = $clog2(NPART + 1);
   localparam int KW     = $clog2(NPART);

   logic            busy;
   logic [CW-1:0]   issue_cnt;
   logic [OPW-1:0]  a_q, b_q;
   logic [OPW-1:0]  src_a, src_b;
   logic            issue;
   int              k_sel;
   logic [SW-1:0]   x_sel, y_sel;
   logic [2*SW-1:0] part;
   logic            pvalid;
   logic [KW-1:0]   pidx;
   logic [PW-1:0]   acc, acc_nxt;
   logic            accept;

   assign accept = !busy && start;

   // Pick the byte pair for this cycle: pair 0 straight from the ports on
   // the accepting cycle, later pairs from the captured operands.
   always_comb begin
      issue = 1'b0;
      k_sel = 0;
      src_a = a_q;
      src_b = b_q;
      if (accept) begin
         issue = 1'b1;
         src_a = a;
         src_b = b;
      end else if (busy && (issue_cnt < CW'(NPART))) begin
         issue = 1'b1;
         k_sel = int'(issue_cnt);
      end
      x_sel = src_a[(k_sel % NSLICE)*SW +: SW];
      y_sel = src_b[(k_sel / NSLICE)*SW +: SW];
   end

   mulw_slice #(.SW(SW)) u_slice (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (issue),
      .x    (x_sel),
      .y    (y_sel),
      .p    (part)
   );

   always_comb begin
      acc_nxt = (pidx == '0) ? '0 : acc;
      acc_nxt = acc_nxt +
                ({{(PW-2*SW){1'b0}}, part} << part_shift(int'(pidx), NSLICE, SW));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         issue_cnt <= '0;
         a_q       <= '0;
         b_q       <= '0;
         pvalid    <= 1'b0;
         pidx      <= '0;
         acc       <= '0;
         product   <= '0;
         done      <= 1'b0;
      end else begin
         done   <= 1'b0;
         pvalid <= issue;
         if (issue) pidx <= KW'(k_sel);
         if (accept) begin
            busy      <= 1'b1;
            a_q       <= a;
            b_q       <= b;
            issue_cnt <= CW'(1);
         end else if (issue) begin
            issue_cnt <= issue_cnt + CW'(1);
         end
         if (pvalid) begin
            acc <= acc_nxt;
            if (pidx == KW'(NPART-1)) begin
               product <= acc_nxt;
               done    <= 1'b1;
               busy    <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/bytewise_mul.sv
module bytewise_mul #(
   parameter int                  OPW  = 16,
   parameter int                  SW   = 8,
   parameter mulw_pkg::mul_arch_e ARCH = mulw_pkg::MUL_PARALLEL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OPW-1:0]   a,
   input  logic [OPW-1:0]   b,
   output logic             done,
   output logic [2*OPW-1:0] product
);

   localparam int NSLICE = OPW / SW;

   if (SW < 1 || (OPW % SW) != 0)
      $error("operand width must be a whole number of slices");
   if (NSLICE < 2)
      $error("operand must span at least two slices");

   if (ARCH == mulw_pkg::MUL_SERIAL) begin : g_serial
      mulw_ser #(.OPW(OPW), .SW(SW)) u_core (
         .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
         .done(done), .product(product)
      );
   end else begin : g_parallel
      mulw_par #(.OPW(OPW), .SW(SW)) u_core (
         .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
         .done(done), .product(product)
      );
   end

endmodule

// File: rtl/bytewise_mul_chk.sv
module bytewise_mul_chk #(
   parameter int                  OPW  = 16,
   parameter int                  SW   = 8,
   parameter mulw_pkg::mul_arch_e ARCH = mulw_pkg::MUL_PARALLEL
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [OPW-1:0]   a,
   input logic [OPW-1:0]   b,
   input logic             done,
   input logic [2*OPW-1:0] product
);
   localparam int NSLICE = OPW / SW;
   localparam int NPART  = NSLICE * NSLICE;
   localparam int PW     = 2 * OPW;
   localparam bit SER    = (ARCH == mulw_pkg::MUL_SERIAL);

   int             cnt;
   logic [OPW-1:0] ea, eb;
   logic [PW-1:0]  expv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= 0;
         ea  <= '0;
         eb  <= '0;
      end else begin
         if (start && (!SER || cnt == 0)) begin
            ea <= a;
            eb <= b;
         end
         if (cnt == 0 && start)  cnt <= 1;
         else if (cnt == NPART)  cnt <= 0;
         else if (cnt != 0)      cnt <= cnt + 1;
      end
   end

   assign expv = PW'(ea) * PW'(eb);

   p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> product == expv);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(product));

   p_reset_r7: assert property (@(posedge clk)
      !rst_n |=> (!done && product == '0));

   if (SER) begin : g_ser_props
      p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt == NPART) |=> done);
      p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt != NPART) |=> !done);
      p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
         done |=> !done);
   end else begin : g_par_props
      p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
         start |=> done);
      p_nodone_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !start |=> !done);
   end

endmodule

bind bytewise_mul bytewise_mul_chk #(.OPW(OPW), .SW(SW), .ARCH(ARCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
   .done(done), .product(product)
);

// File: tb/bytewise_mul_tb_top.sv
module bytewise_mul_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p_start = 1'b0, s_start = 1'b0;
   logic [15:0] p_a = '0, p_b = '0, s_a = '0, s_b = '0;
   logic        p_done, s_done;
   logic [31:0] p_prod, s_prod;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   bytewise_mul #(.OPW(16), .SW(8), .ARCH(mulw_pkg::MUL_SERIAL)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(s_start), .a(s_a), .b(s_b),
      .done(s_done), .product(s_prod)
   );

   bytewise_mul #(.OPW(16), .SW(8), .ARCH(mulw_pkg::MUL_PARALLEL)) dut_par_i (
      .clk(clk), .rst_n(rst_n), .start(p_start), .a(p_a), .b(p_b),
      .done(p_done), .product(p_prod)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Parallel: one request, result on the next cycle (R1, R2).
   task automatic par_one(input logic [15:0] x, input logic [15:0] y, input string req);
      p_a = x; p_b = y; p_start = 1'b1;
      @(negedge clk);
      p_start = 1'b0;
      chk(p_done == 1'b1, {req, " par done"}, 32'(p_done), 32'd1);
      chk(p_prod == 32'(x) * 32'(y), {req, " par product"}, p_prod, 32'(x) * 32'(y));
   endtask

   // Serial: one request, done exactly after the fourth edge (R1, R3, R4).
   task automatic ser_one(input logic [15:0] x, input logic [15:0] y, input string req);
      s_a = x; s_b = y; s_start = 1'b1;
      @(negedge clk);
      s_start = 1'b0;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         chk(s_done == (k == 4), {req, " R3 ser done timing"}, 32'(s_done), 32'(k == 4));
      end
      chk(s_prod == 32'(x) * 32'(y), {req, " ser product"}, s_prod, 32'(x) * 32'(y));
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!p_done && p_prod == 32'd0, "R7 parallel reset", p_prod, 32'd0);
      chk(!s_done && s_prod == 32'd0, "R7 serial reset", s_prod, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_par_patterns;
      par_one(16'h1234, 16'h5678, "R1");
      par_one(16'h00FF, 16'hFF00, "R1");
      par_one(16'hA5A5, 16'h5A5A, "R1");
   endtask

   task automatic t_par_b2b;
      p_a = 16'h0003; p_b = 16'h0007; p_start = 1'b1;
      @(negedge clk);
      chk(p_done && p_prod == 32'd21, "R2 b2b first", p_prod, 32'd21);
      p_a = 16'hBEEF; p_b = 16'h0101;
      @(negedge clk);
      p_start = 1'b0;
      chk(p_done && p_prod == 32'hBEEF * 32'h0101, "R2 b2b second", p_prod, 32'hBEEF * 32'h0101);
      @(negedge clk);
      chk(!p_done, "R2 no done without start", 32'(p_done), 32'd0);
      chk(p_prod == 32'hBEEF * 32'h0101, "R6 parallel hold", p_prod, 32'hBEEF * 32'h0101);
   endtask

   task automatic t_corners;
      par_one(16'hFFFF, 16'hFFFF, "R8");
      chk(p_prod == 32'hFFFE0001, "R8 all ones parallel", p_prod, 32'hFFFE0001);
      par_one(16'h0000, 16'hBEEF, "R8");
      par_one(16'h0100, 16'h0100, "R8");
      ser_one(16'hFFFF, 16'hFFFF, "R8");
      chk(s_prod == 32'hFFFE0001, "R8 all ones serial", s_prod, 32'hFFFE0001);
      ser_one(16'hCAFE, 16'h0000, "R8");
      ser_one(16'h0100, 16'h0100, "R8");
   endtask

   task automatic t_ser_patterns;
      ser_one(16'h1234, 16'h5678, "R1");
      ser_one(16'h00FF, 16'hFF00, "R1");
      @(negedge clk);
      chk(!s_done, "R4 single pulse", 32'(s_done), 32'd0);
   endtask

   task automatic t_ser_ignore;
      s_a = 16'h0102; s_b = 16'h0304; s_start = 1'b1;
      @(negedge clk);
      s_a = 16'hFFFF; s_b = 16'hFFFF;          // start stays high while busy
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (k == 3) s_start = 1'b0;
         chk(s_done == (k == 4), "R5 done timing with ignored start", 32'(s_done), 32'(k == 4));
      end
      chk(s_prod == 32'h0102 * 32'h0304, "R5 ignored operands", s_prod, 32'h0102 * 32'h0304);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(!s_done, "R5 no extra done", 32'(s_done), 32'd0);
      end
      chk(s_prod == 32'h0102 * 32'h0304, "R6 serial hold", s_prod, 32'h0102 * 32'h0304);
   endtask

   task automatic t_ser_chain;
      ser_one(16'h0011, 16'h0022, "R9");
      // now in the done cycle: offer a new request
      ser_one(16'h4321, 16'h8765, "R9");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset;
      t_par_patterns;
      t_par_b2b;
      t_ser_patterns;
      t_ser_ignore;
      t_ser_chain;
      t_corners;
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule